// File: doc/BRIEF.md
# Isochronous IN Double-Buffer Controller

This block keeps the bookkeeping for a two-slot IN packet buffer on each of up to four isochronous device endpoints. It decides when a loaded packet may go out on the bus. A packet is loaded in one of two ways. Software can strobe a per-endpoint buffer-ready bit. In auto-set mode, a byte counter recognises that a full max-packet-size worth of bytes has been written into the endpoint FIFO. The serial engine tells the block that a packet has left the buffer through a per-endpoint transmit-done strobe.

A single global deferral switch changes timing for endpoints that are marked isochronous. With the switch on, a newly loaded packet is held back and only becomes sendable at the next start-of-frame. A packet loaded during frame n therefore leaves during frame n+1. A frame pulse may come from a received token or from the internal substitute-frame generator; the two are treated the same. With auto-flush also enabled, a frame pulse that finds both slots occupied throws away the older packet before releasing what is left. This keeps a stalled host from making the stream fall further behind.

Top module: `iso_in_dbuf_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every endpoint's status to 0, its ready flag to 0, its read-slot index to 0 and its byte counter to 0.
- R2: When deferral is off, a load event raises the endpoint's status by one and sets its ready flag. Both outputs change on the clock edge that samples the event.
- R3: When an endpoint's auto-set bit is 1, the byte write that brings its byte count up to the max packet size is a load event, and the count restarts from zero. A max packet size of 0 or 1 makes every byte write a load. While auto-set is 0, byte writes do nothing and the count stays at zero.
- R4: For an endpoint with its ISO bit set while deferral is on, a load raises the status but not the ready flag. The next frame pulse (host `sof_host` or artificial `sof_art`) releases every held packet. A load in the same cycle as a frame pulse waits for the following pulse.
- R5: When auto-flush, deferral and the ISO bit are all 1, and the status is 2 at a frame pulse, the oldest packet is discarded. The status drops by one and the read-slot index toggles.
- R6: On a frame pulse that both flushes and releases, the flush is applied first and the remaining packet is then marked ready.
- R7: A transmit-done strobe while the ready flag is 1 lowers the status by one and toggles the read-slot index. While the ready flag is 0 the strobe is ignored.
- R8: A load event while the status is 2 is dropped, and no output changes because of it.
- R9: `buf_sts[2i+1:2i]` holds endpoint i's packet count as binary 0, 1 or 2 and never 3. `tx_ready[i]` is 1 only while that count is non-zero.
- R10: An endpoint whose ISO bit is 0 always takes the immediate path and is never flushed, whatever the deferral and auto-flush bits hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_defer | input | 1 | Global deferral enable for ISO IN endpoints |
| cfg_autoflush | input | 1 | Global auto-flush enable |
| ep_iso | input | NUM_EP | Per-endpoint isochronous mode bit |
| ep_autoset | input | NUM_EP | Per-endpoint auto-set mode bit |
| ep_maxp | input | NUM_EP*MAXP_W | Per-endpoint max packet size in bytes, endpoint i at bits [i*MAXP_W +: MAXP_W] |
| cpu_rdy_wr | input | NUM_EP | Per-endpoint buffer-ready strobe from software |
| fifo_wr | input | NUM_EP | Per-endpoint FIFO byte-write strobe |
| tx_done | input | NUM_EP | Per-endpoint packet-sent strobe from the serial engine |
| sof_host | input | 1 | Frame pulse decoded from the host |
| sof_art | input | 1 | Frame pulse from the substitute generator |
| tx_ready | output | NUM_EP | Per-endpoint ready-to-transmit flag |
| buf_sts | output | 2*NUM_EP | Per-endpoint packet count (0..2) |
| rd_slot | output | NUM_EP | Per-endpoint index of the slot holding the oldest packet |

## Verification
A frame pulse can fall in the same cycle as a load, as a transmit-done strobe, or as both, on an endpoint that is already full. In that cycle the flush, the acknowledge, the release and the load all act on one count. Directed steps force each pairing on a deferred endpoint. Random traffic on all four endpoints, with frequent host and artificial frame pulses, reaches the rest. Each cycle is judged against a bench model that applies the rules in the fixed order flush, acknowledge, release, load, and the status, ready flag and read slot are compared one cycle after the stimulus.

// File: rtl/iso_in_pkg.sv
package iso_in_pkg;
  typedef logic [1:0] pkt_cnt_t;
  localparam pkt_cnt_t CNT_EMPTY = 2'd0;
  localparam pkt_cnt_t CNT_FULL  = 2'd2;
endpackage

// File: rtl/iso_pkt_counter.sv
module iso_pkt_counter #(
  parameter int MAXP_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              autoset,
  input  logic              byte_wr,
  input  logic [MAXP_W-1:0] maxp,
  output logic              pkt_done
);
  logic [MAXP_W-1:0] cnt_q;
  logic [MAXP_W:0]   cnt_inc;
  logic              at_limit;

  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
  assign at_limit = cnt_inc >= {1'b0, maxp};
  assign pkt_done = autoset && byte_wr && at_limit;

  always_ff @(posedge clk) begin
    if (rst || !autoset) begin
      cnt_q <= '0;
    end else if (byte_wr) begin
      if (at_limit) cnt_q <= '0;
      else          cnt_q <= cnt_inc[MAXP_W-1:0];
    end
  end
endmodule

// File: rtl/iso_ep_state.sv
module iso_ep_state
  import iso_in_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     deferred,
  input  logic     flush_en,
  input  logic     sof,
  input  logic     load,
  input  logic     ack,
  output pkt_cnt_t occ,
  output logic     ready,
  output logic     rd_slot
);
  pkt_cnt_t occ_q, rel_q;
  pkt_cnt_t occ_d, rel_d;
  logic     ready_q, slot_q;
  logic     do_flush, do_ack, do_load;

  always_comb begin
    occ_d    = occ_q;
    rel_d    = rel_q;
    do_flush = sof && flush_en && (occ_q == CNT_FULL);
    if (do_flush) begin
      occ_d = occ_d - 2'd1;
      if (rel_d != CNT_EMPTY) rel_d = rel_d - 2'd1;
    end
    do_ack = ack && (rel_d != CNT_EMPTY);
    if (do_ack) begin
      occ_d = occ_d - 2'd1;
      rel_d = rel_d - 2'd1;
    end
    if (sof && deferred) rel_d = occ_d;
    do_load = load && (occ_d != CNT_FULL);
    if (do_load) begin
      occ_d = occ_d + 2'd1;
      if (!deferred) rel_d = rel_d + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q   <= CNT_EMPTY;
      rel_q   <= CNT_EMPTY;
      ready_q <= 1'b0;
      slot_q  <= 1'b0;
    end else begin
      occ_q   <= occ_d;
      rel_q   <= rel_d;
      ready_q <= (rel_d != CNT_EMPTY);
      slot_q  <= slot_q ^ do_flush ^ do_ack;
    end
  end

  assign occ     = occ_q;
  assign ready   = ready_q;
  assign rd_slot = slot_q;
endmodule

// File: rtl/iso_in_dbuf_ctrl.sv
module iso_in_dbuf_ctrl #(
  parameter int NUM_EP = 4,
  parameter int MAXP_W = 11
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_defer,
  input  logic                     cfg_autoflush,
  input  logic [NUM_EP-1:0]        ep_iso,
  input  logic [NUM_EP-1:0]        ep_autoset,
  input  logic [NUM_EP*MAXP_W-1:0] ep_maxp,
  input  logic [NUM_EP-1:0]        cpu_rdy_wr,
  input  logic [NUM_EP-1:0]        fifo_wr,
  input  logic [NUM_EP-1:0]        tx_done,
  input  logic                     sof_host,
  input  logic                     sof_art,
  output logic [NUM_EP-1:0]        tx_ready,
  output logic [2*NUM_EP-1:0]      buf_sts,
  output logic [NUM_EP-1:0]        rd_slot
);
  localparam int STS_W = 2;
  logic sof_any;
  assign sof_any = sof_host | sof_art;

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    logic auto_pkt, ep_defer, ep_flush;
    iso_in_pkg::pkt_cnt_t cnt;

    assign ep_defer = cfg_defer && ep_iso[e];
    assign ep_flush = ep_defer && cfg_autoflush;

    iso_pkt_counter #(.MAXP_W(MAXP_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .autoset  (ep_autoset[e]),
      .byte_wr  (fifo_wr[e]),
      .maxp     (ep_maxp[e*MAXP_W +: MAXP_W]),
      .pkt_done (auto_pkt)
    );

    iso_ep_state u_st (
      .clk      (clk),
      .rst      (rst),
      .deferred (ep_defer),
      .flush_en (ep_flush),
      .sof      (sof_any),
      .load     (cpu_rdy_wr[e] | auto_pkt),
      .ack      (tx_done[e]),
      .occ      (cnt),
      .ready    (tx_ready[e]),
      .rd_slot  (rd_slot[e])
    );

    assign buf_sts[e*STS_W +: STS_W] = cnt;
  end
endmodule

// File: rtl/iso_in_dbuf_chk.sv
module iso_in_dbuf_chk #(
  parameter int NUM_EP = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                cfg_defer,
  input logic                cfg_autoflush,
  input logic [NUM_EP-1:0]   ep_iso,
  input logic [NUM_EP-1:0]   cpu_rdy_wr,
  input logic [NUM_EP-1:0]   fifo_wr,
  input logic [NUM_EP-1:0]   tx_done,
  input logic                sof_host,
  input logic                sof_art,
  input logic [NUM_EP-1:0]   tx_ready,
  input logic [2*NUM_EP-1:0] buf_sts,
  input logic [NUM_EP-1:0]   rd_slot
);
  logic sof_any;
  assign sof_any = sof_host | sof_art;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (buf_sts == '0 && tx_ready == '0 && rd_slot == '0)); // R1

  for (genvar e = 0; e < NUM_EP; e++) begin : g_a
    AST_STS_NEVER_THREE: assert property (@(posedge clk) disable iff (rst)
      buf_sts[2*e +: 2] != 2'd3); // R9

    AST_READY_HAS_PACKET: assert property (@(posedge clk) disable iff (rst)
      tx_ready[e] |-> buf_sts[2*e +: 2] != 2'd0); // R9

    AST_DEFER_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (cfg_defer && ep_iso[e] && !sof_any && !tx_ready[e]) |=> !tx_ready[e]); // R4

    AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (rst)
      (sof_any && cfg_defer && cfg_autoflush && ep_iso[e] && buf_sts[2*e +: 2] == 2'd2
       && !cpu_rdy_wr[e] && !fifo_wr[e]) |=> buf_sts[2*e +: 2] != 2'd2); // R5

    AST_FLUSH_SLOT: assert property (@(posedge clk) disable iff (rst)
      (sof_any && cfg_defer && cfg_autoflush && ep_iso[e] && buf_sts[2*e +: 2] == 2'd2
       && !tx_done[e]) |=> rd_slot[e] != $past(rd_slot[e])); // R5

    AST_IDLE_ACK: assert property (@(posedge clk) disable iff (rst)
      (tx_done[e] && !tx_ready[e] && !sof_any && !cpu_rdy_wr[e] && !fifo_wr[e])
      |=> $stable(buf_sts[2*e +: 2]) && $stable(rd_slot[e])); // R7
  end
endmodule

bind iso_in_dbuf_ctrl iso_in_dbuf_chk #(.NUM_EP(NUM_EP)) u_chk (
  .clk(clk), .rst(rst), .cfg_defer(cfg_defer), .cfg_autoflush(cfg_autoflush),
  .ep_iso(ep_iso), .cpu_rdy_wr(cpu_rdy_wr), .fifo_wr(fifo_wr), .tx_done(tx_done),
  .sof_host(sof_host), .sof_art(sof_art), .tx_ready(tx_ready), .buf_sts(buf_sts),
  .rd_slot(rd_slot)
);

// File: tb/sim_iso_in_dbuf_ctrl.sv
`timescale 1ns/1ps
module sim_iso_in_dbuf_ctrl;
  localparam int NE = 4;
  localparam int MW = 11;

  logic clk = 1'b0;
  logic rst;
  logic cfg_defer, cfg_autoflush, sof_host, sof_art;
  logic [NE-1:0] ep_iso, ep_autoset, cpu_rdy_wr, fifo_wr, tx_done;
  logic [NE*MW-1:0] ep_maxp;
  logic [NE-1:0] tx_ready, rd_slot;
  logic [2*NE-1:0] buf_sts;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_occ [NE];
  int m_rel [NE];
  int m_bc  [NE];
  bit m_rd  [NE];

  always #5 clk = ~clk;

  iso_in_dbuf_ctrl #(.NUM_EP(NE), .MAXP_W(MW)) u0 (
    .clk(clk), .rst(rst), .cfg_defer(cfg_defer), .cfg_autoflush(cfg_autoflush),
    .ep_iso(ep_iso), .ep_autoset(ep_autoset), .ep_maxp(ep_maxp),
    .cpu_rdy_wr(cpu_rdy_wr), .fifo_wr(fifo_wr), .tx_done(tx_done),
    .sof_host(sof_host), .sof_art(sof_art),
    .tx_ready(tx_ready), .buf_sts(buf_sts), .rd_slot(rd_slot)
  );

  function automatic logic [3:0] expect_of(int e);
    return {2'(m_occ[e]), m_rel[e] != 0, m_rd[e]};
  endfunction

  task automatic clear_strobes();
    cpu_rdy_wr = '0; fifo_wr = '0; tx_done = '0; sof_host = 0; sof_art = 0;
  endtask

  task automatic model_step();
    bit sof = sof_host | sof_art;
    for (int e = 0; e < NE; e++) begin
      bit dfr = cfg_defer && ep_iso[e];
      int mp = int'(ep_maxp[e*MW +: MW]);
      bit ld = cpu_rdy_wr[e];
      if (!ep_autoset[e]) m_bc[e] = 0;
      else if (fifo_wr[e]) begin
        if (m_bc[e] + 1 >= mp) begin ld = 1; m_bc[e] = 0; end
        else m_bc[e] = m_bc[e] + 1;
      end
      if (sof && dfr && cfg_autoflush && m_occ[e] == 2) begin
        m_occ[e]--; if (m_rel[e] > 0) m_rel[e]--; m_rd[e] = !m_rd[e];
      end
      if (tx_done[e] && m_rel[e] > 0) begin
        m_occ[e]--; m_rel[e]--; m_rd[e] = !m_rd[e];
      end
      if (sof && dfr) m_rel[e] = m_occ[e];
      if (ld && m_occ[e] < 2) begin
        m_occ[e]++; if (!dfr) m_rel[e]++;
      end
    end
  endtask

  task automatic compare(string tag);
    for (int e = 0; e < NE; e++) begin
      logic [3:0] act = {buf_sts[2*e +: 2], tx_ready[e], rd_slot[e]};
      logic [3:0] exp = expect_of(e);
      n_chk++;
      if (act !== exp) begin
        n_fail++;
        $display("FAIL %s ep%0d {sts,rdy,slot} actual=%b expected=%b", tag, e, act, exp);
      end
    end
  endtask

  task automatic step(string tag);
    model_step();
    @(posedge clk); #1;
    compare(tag);
    clear_strobes();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20061016));
    rst = 1; cfg_defer = 0; cfg_autoflush = 0; ep_iso = '0; ep_autoset = '0;
    ep_maxp = '0; clear_strobes();
    for (int e = 0; e < NE; e++) begin m_occ[e] = 0; m_rel[e] = 0; m_bc[e] = 0; m_rd[e] = 0; end
    repeat (3) @(posedge clk); #1;
    compare("R1");
    rst = 0;

    cpu_rdy_wr[0] = 1; step("R2");
    cpu_rdy_wr[0] = 1; step("R2");
    cpu_rdy_wr[0] = 1; step("R8");
    tx_done[0] = 1; step("R7");
    tx_done[2] = 1; step("R7");

    cfg_defer = 1; cfg_autoflush = 1;
    cpu_rdy_wr[1] = 1; sof_host = 1; step("R10");
    cpu_rdy_wr[1] = 1; step("R10");
    sof_art = 1; step("R10");

    ep_autoset[2] = 1; ep_maxp[2*MW +: MW] = 11'd3;
    fifo_wr[2] = 1; step("R3");
    fifo_wr[2] = 1; step("R3");
    fifo_wr[2] = 1; step("R3");
    ep_autoset[2] = 0; fifo_wr[2] = 1; step("R3");
    ep_autoset[2] = 1; ep_maxp[2*MW +: MW] = 11'd0; fifo_wr[2] = 1; step("R3");

    ep_iso[3] = 1;
    cpu_rdy_wr[3] = 1; step("R4");
    step("R4");
    cpu_rdy_wr[3] = 1; sof_host = 1; step("R4");
    sof_art = 1; step("R5");
    cpu_rdy_wr[3] = 1; step("R6");
    sof_host = 1; tx_done[3] = 1; step("R6");
    cpu_rdy_wr[3] = 1; step("R6");
    sof_art = 1; step("R6");

    for (int c = 0; c < 4000; c++) begin
      if (c % 150 == 0) begin
        cfg_defer = 1'($urandom % 4 != 0);
        cfg_autoflush = 1'($urandom % 3 != 0);
        ep_iso = 4'($urandom); ep_autoset = 4'($urandom);
        for (int e = 0; e < NE; e++) ep_maxp[e*MW +: MW] = 11'($urandom % 5);
      end
      for (int e = 0; e < NE; e++) begin
        cpu_rdy_wr[e] = ($urandom % 5) == 0;
        fifo_wr[e]    = ($urandom % 2) == 0;
        tx_done[e]    = ($urandom % 3) == 0;
      end
      sof_host = ($urandom % 12) == 0;
      sof_art  = ($urandom % 30) == 0;
      step("R9");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule